// File: doc/BRIEF.md
# Error Diagnostic Logger

This block keeps a record of data errors reported by an error-correction datapath. It runs on the syndrome clock. On each edge where the datapath flags an error it logs that error. One group of registers holds the first error seen since the last clear: its check bits, its syndrome, whether it was single or multiple, and the whole failing data word. A second syndrome register is overwritten by every error. A 4-bit counter tallies errors and stops at its maximum.

A read-out multiplexer presents the log in one of two views. The diagnostic view is a packed 38-bit word. It combines every logged field with the live check bits the datapath is producing at that moment. The error-data view presents the captured failing word. A synchronous clear empties the log and re-arms first-error capture.

Top module: `edl_diag_log`

## Requirements
- R1: After reset or after a cycle with `clr_i` high, every logged field reads zero and the next error is treated as the first error.
- R2: On an edge where `err_i` is low and `clr_i` is low, no logged field changes.
- R3: On the first edge with `err_i` high after reset or clear, the log captures four things: `cb_i` into diagnostic bits 15:8, `syn_i` into bits 16:23 (LSB at 16), `data_i` into the error-data register, and the error type. The type sets bit 28 to 1 and bit 29 to `merr_i`.
- R4: Later errors leave bits 8–23, 28, 29 and the error-data register unchanged until the next clear or reset.
- R5: Bits 37:30 take `syn_i` on every edge with `err_i` high.
- R6: Bits 27:24 count edges with `err_i` high, increment by one each time and saturate at 15.
- R7: Bits 7:0 of the diagnostic view follow `cb_live_i` combinationally, independent of any error or clear.
- R8: With `view_i` = 0 the output is the 38-bit diagnostic word, zero-extended to 64 bits. With `view_i` = 1 the output is the error-data register.
- R9: When `clr_i` and `err_i` are high on the same edge, the clear wins and nothing is logged. The next error after that edge is captured as a first error.
- R10: `merr_i` high while `err_i` is low is not an error: nothing is logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_syn | input | 1 | Syndrome clock; all log registers load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous log clear, priority over logging |
| err_i | input | 1 | Error present on this edge |
| merr_i | input | 1 | Error is multiple-bit (valid with `err_i`) |
| syn_i | input | 8 | Syndrome of the current word |
| cb_i | input | 8 | Check bits read with the current word |
| cb_live_i | input | 8 | Live check-bit latch contents |
| data_i | input | 64 | Current data word |
| view_i | input | 1 | 0 = diagnostic view, 1 = error-data view |
| dout_o | output | 64 | Selected log view |

## Verification
The bench targets the boundary between the first error and later ones. A design that misses the capture-taken state would keep overwriting the first-error syndrome, check bits or data word. The counter is driven through 15 and beyond; an unsaturated counter would wrap to zero. Two more cases are driven: a clear that coincides with an error, and a multiple-error flag without an error flag. A design with the wrong priority, or one that treats `merr_i` alone as an error, would log an entry where none belongs. Each view is read after every edge, so a swapped field or a stale live check-bit path shows up at once.

// File: rtl/edl_diag_pkg.sv
package edl_diag_pkg;
  typedef enum logic {
    VIEW_DIAG = 1'b0,
    VIEW_DATA = 1'b1
  } edl_view_e;

  localparam int unsigned EDL_CW_DEF   = 8;
  localparam int unsigned EDL_DW_DEF   = 64;
  localparam int unsigned EDL_CNTW_DEF = 4;
endpackage

// File: rtl/edl_first_capture.sv
module edl_first_capture #(
  parameter int unsigned CW = 8,
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          err,
  input  logic          merr,
  input  logic [CW-1:0] cb,
  input  logic [CW-1:0] syn,
  input  logic [DW-1:0] data,
  output logic          taken,
  output logic          first_merr,
  output logic [CW-1:0] first_cb,
  output logic [CW-1:0] first_syn,
  output logic [DW-1:0] first_data
);
  logic          taken_q, taken_d;
  logic          merr_q, merr_d;
  logic [CW-1:0] cb_q, cb_d;
  logic [CW-1:0] syn_q, syn_d;
  logic [DW-1:0] data_q, data_d;
  logic          load;

  assign load = err && !clr && !taken_q;

  always_comb begin
    taken_d = taken_q;
    merr_d  = merr_q;
    cb_d    = cb_q;
    syn_d   = syn_q;
    data_d  = data_q;
    if (clr) begin
      taken_d = 1'b0;
      merr_d  = 1'b0;
      cb_d    = '0;
      syn_d   = '0;
      data_d  = '0;
    end else if (load) begin
      taken_d = 1'b1;
      merr_d  = merr;
      cb_d    = cb;
      syn_d   = syn;
      data_d  = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      merr_q  <= 1'b0;
      cb_q    <= '0;
      syn_q   <= '0;
      data_q  <= '0;
    end else if (clr || load) begin
      taken_q <= taken_d;
      merr_q  <= merr_d;
      cb_q    <= cb_d;
      syn_q   <= syn_d;
      data_q  <= data_d;
    end
  end

  assign taken      = taken_q;
  assign first_merr = merr_q;
  assign first_cb   = cb_q;
  assign first_syn  = syn_q;
  assign first_data = data_q;
endmodule

// File: rtl/edl_err_counter.sv
module edl_err_counter #(
  parameter int unsigned CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            err,
  output logic [CNTW-1:0] count
);
  localparam logic [CNTW-1:0] CNT_MAX = {CNTW{1'b1}};

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign cnt_en = clr || (err && (cnt_q != CNT_MAX));

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/edl_last_syn.sv
module edl_last_syn #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          err,
  input  logic [CW-1:0] syn,
  output logic [CW-1:0] last_syn
);
  logic [CW-1:0] syn_q, syn_d;
  logic          en;

  assign en    = clr || err;
  assign syn_d = clr ? '0 : syn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  syn_q <= '0;
    else if (en) syn_q <= syn_d;
  end

  assign last_syn = syn_q;
endmodule

// File: rtl/edl_diag_log.sv
module edl_diag_log
  import edl_diag_pkg::*;
#(
  parameter int unsigned CW   = EDL_CW_DEF,
  parameter int unsigned DW   = EDL_DW_DEF,
  parameter int unsigned CNTW = EDL_CNTW_DEF
) (
  input  logic          clk_syn,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          err_i,
  input  logic          merr_i,
  input  logic [CW-1:0] syn_i,
  input  logic [CW-1:0] cb_i,
  input  logic [CW-1:0] cb_live_i,
  input  logic [DW-1:0] data_i,
  input  logic          view_i,
  output logic [((DW > 4*CW+CNTW+2) ? DW : (4*CW+CNTW+2))-1:0] dout_o
);
  localparam int unsigned DIAGW = 4*CW + CNTW + 2;
  localparam int unsigned OUTW  = (DW > DIAGW) ? DW : DIAGW;

  logic            taken;
  logic            first_merr;
  logic [CW-1:0]   first_cb;
  logic [CW-1:0]   first_syn;
  logic [DW-1:0]   first_data;
  logic [CNTW-1:0] count;
  logic [CW-1:0]   last_syn;
  logic [DIAGW-1:0] diag_w;
  edl_view_e       view;

  edl_first_capture #(.CW(CW), .DW(DW)) u_first (
    .clk(clk_syn), .rst_n(rst_n), .clr(clr_i), .err(err_i), .merr(merr_i),
    .cb(cb_i), .syn(syn_i), .data(data_i),
    .taken(taken), .first_merr(first_merr), .first_cb(first_cb),
    .first_syn(first_syn), .first_data(first_data)
  );

  edl_err_counter #(.CNTW(CNTW)) u_cnt (
    .clk(clk_syn), .rst_n(rst_n), .clr(clr_i), .err(err_i), .count(count)
  );

  edl_last_syn #(.CW(CW)) u_last (
    .clk(clk_syn), .rst_n(rst_n), .clr(clr_i), .err(err_i), .syn(syn_i),
    .last_syn(last_syn)
  );

  // packed diagnostic view, LSB first: live cb, first cb, first syn, count, type, last syn
  assign diag_w = {last_syn, first_merr, taken, count, first_syn, first_cb, cb_live_i};
  assign view   = edl_view_e'(view_i);

  always_comb begin
    dout_o = '0;
    if (view == VIEW_DATA) dout_o[DW-1:0]    = first_data;
    else                   dout_o[DIAGW-1:0] = diag_w;
  end
endmodule

// File: rtl/edl_diag_log_chk.sv
module edl_diag_log_chk #(
  parameter int unsigned CW   = 8,
  parameter int unsigned CNTW = 4
) (
  input logic                      clk_syn,
  input logic                      rst_n,
  input logic                      clr_i,
  input logic                      err_i,
  input logic [CW-1:0]             syn_i,
  input logic [4*CW+CNTW+1:0]      diag_w
);
  localparam int unsigned CNT_LO = 3*CW;
  localparam int unsigned TYP_LO = 3*CW + CNTW;
  localparam int unsigned LSY_LO = TYP_LO + 2;
  localparam logic [CNTW-1:0] CMAX = {CNTW{1'b1}};

  logic [CNTW-1:0] cnt_v;
  logic [CW-1:0]   lsyn_v;
  logic [CW-1:0]   fsyn_v;
  logic            ferr_v;
  logic [2*CW+1:0] first_v;

  assign cnt_v   = diag_w[CNT_LO +: CNTW];
  assign lsyn_v  = diag_w[LSY_LO +: CW];
  assign fsyn_v  = diag_w[2*CW +: CW];
  assign ferr_v  = diag_w[TYP_LO];
  assign first_v = {diag_w[TYP_LO +: 2], diag_w[CW +: 2*CW]};

  // R1
  clear_zero_chk: assert property (@(posedge clk_syn) disable iff (!rst_n)
    clr_i |=> (diag_w[4*CW+CNTW+1:CW] == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk_syn) disable iff (!rst_n)
    (!clr_i && !err_i) |=> $stable(diag_w[4*CW+CNTW+1:CW]));

  // R3
  first_load_chk: assert property (@(posedge clk_syn) disable iff (!rst_n)
    (err_i && !clr_i && !ferr_v) |=> (ferr_v && fsyn_v == $past(syn_i)));

  // R4
  first_hold_chk: assert property (@(posedge clk_syn) disable iff (!rst_n)
    (!clr_i && ferr_v) |=> $stable(first_v));

  // R5
  last_syn_chk: assert property (@(posedge clk_syn) disable iff (!rst_n)
    (err_i && !clr_i) |=> (lsyn_v == $past(syn_i)));

  // R6
  count_step_chk: assert property (@(posedge clk_syn) disable iff (!rst_n)
    (err_i && !clr_i && cnt_v != CMAX) |=> (cnt_v == $past(cnt_v) + 1'b1));

  // R6
  count_sat_chk: assert property (@(posedge clk_syn) disable iff (!rst_n)
    (!clr_i && cnt_v == CMAX) |=> (cnt_v == CMAX));
endmodule

bind edl_diag_log edl_diag_log_chk #(.CW(CW), .CNTW(CNTW)) u_chk (
  .clk_syn(clk_syn), .rst_n(rst_n), .clr_i(clr_i), .err_i(err_i),
  .syn_i(syn_i), .diag_w(diag_w)
);

// File: tb/edl_diag_log_bench.sv
module edl_diag_log_bench;
  logic        clk_syn = 1'b0;
  logic        rst_n   = 1'b0;
  logic        clr_i   = 1'b0;
  logic        err_i   = 1'b0;
  logic        merr_i  = 1'b0;
  logic [7:0]  syn_i   = '0;
  logic [7:0]  cb_i    = '0;
  logic [7:0]  cb_live_i = '0;
  logic [63:0] data_i  = '0;
  logic        view_i  = 1'b0;
  logic [63:0] dout_o;

  int checks   = 0;
  int failures = 0;

  // behavioural reference state
  bit          m_taken;
  bit          m_merr;
  int          m_cnt;
  logic [7:0]  m_fcb, m_fsyn, m_lsyn;
  logic [63:0] m_fdata;

  always #4 clk_syn = ~clk_syn;

  edl_diag_log u_edl_diag_log (
    .clk_syn(clk_syn), .rst_n(rst_n), .clr_i(clr_i), .err_i(err_i),
    .merr_i(merr_i), .syn_i(syn_i), .cb_i(cb_i), .cb_live_i(cb_live_i),
    .data_i(data_i), .view_i(view_i), .dout_o(dout_o)
  );

  task automatic model_reset();
    m_taken = 0; m_merr = 0; m_cnt = 0;
    m_fcb = 0; m_fsyn = 0; m_lsyn = 0; m_fdata = 0;
  endtask

  function automatic logic [63:0] expected();
    logic [3:0] c4;
    c4 = m_cnt[3:0];
    if (view_i) return m_fdata;
    return {26'b0, m_lsyn, m_merr, m_taken, c4, m_fsyn, m_fcb, cb_live_i};
  endfunction

  task automatic compare(input string tag);
    logic [63:0] exp;
    exp = expected();
    checks++;
    if (dout_o !== exp) begin
      failures++;
      $display("FAIL %s view=%0d actual=%h expected=%h", tag, view_i, dout_o, exp);
    end
  endtask

  // drive one edge's inputs, check the combinational view, clock, update model
  task automatic step(input logic e, input logic m, input logic c,
                      input logic [7:0] s, input logic [7:0] cb,
                      input logic [7:0] live, input logic [63:0] d,
                      input logic v, input string tag);
    err_i = e; merr_i = m; clr_i = c; syn_i = s; cb_i = cb;
    cb_live_i = live; data_i = d; view_i = v;
    #1 compare(tag);
    @(posedge clk_syn);
    if (c) model_reset();
    else if (e) begin
      if (!m_taken) begin
        m_taken = 1; m_merr = m; m_fcb = cb; m_fsyn = s; m_fdata = d;
      end
      m_lsyn = s;
      if (m_cnt < 15) m_cnt++;
    end
    @(negedge clk_syn);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_syn);
    #1 compare("R1");
    rst_n = 1'b1;
    @(negedge clk_syn);

    // R7 / R2: idle with a moving live check-bit latch
    for (int i = 0; i < 4; i++)
      step(0, 0, 0, 8'h11 * i, 8'h3C, 8'h5A ^ i, 64'hDEAD_0000_0000_0000 + i, 0, "R7");
    step(0, 0, 0, 8'h77, 8'h3C, 8'h01, 64'h1, 1, "R2");

    // R3: first error, single-bit
    step(1, 0, 0, 8'h2B, 8'hC4, 8'h10, 64'h0123_4567_89AB_CDEF, 0, "R3");
    step(0, 0, 0, 8'h00, 8'h00, 8'h20, 64'h0, 1, "R3");
    step(0, 0, 0, 8'h00, 8'h00, 8'h30, 64'h0, 0, "R3");

    // R4 / R5: further errors keep the first record, roll last syndrome
    for (int i = 0; i < 5; i++)
      step(1, i[0], 0, 8'h40 + i, 8'h90 + i, 8'hE0 + i,
           64'hFFFF_0000_0000_0000 | i, i[1], (i % 2 == 0) ? "R4" : "R5");
    step(0, 0, 0, 8'h00, 8'h00, 8'hAA, 64'h0, 0, "R5");
    step(0, 0, 0, 8'h00, 8'h00, 8'hAA, 64'h0, 1, "R8");

    // R10: multiple-error flag without the error flag
    step(0, 1, 0, 8'hEE, 8'hEE, 8'h55, 64'hBAD, 0, "R10");
    step(0, 0, 0, 8'h00, 8'h00, 8'h55, 64'h0, 0, "R10");
    step(0, 0, 0, 8'h00, 8'h00, 8'h55, 64'h0, 1, "R10");

    // R6: drive past saturation
    for (int i = 0; i < 14; i++)
      step(1, 0, 0, 8'h80 + i, 8'h01, 8'h0F, 64'h5555 + i, 0, "R6");
    step(0, 0, 0, 8'h00, 8'h00, 8'h0F, 64'h0, 0, "R6");

    // R9: clear coincident with an error
    step(1, 1, 1, 8'hF1, 8'hF2, 8'h0F, 64'hCAFE, 0, "R9");
    step(0, 0, 0, 8'h00, 8'h00, 8'h0F, 64'h0, 0, "R9");
    step(0, 0, 0, 8'h00, 8'h00, 8'h0F, 64'h0, 1, "R9");
    step(1, 1, 0, 8'h3E, 8'h7D, 8'h0F, 64'hA5A5_5A5A_F00D_BEEF, 0, "R9");
    step(1, 0, 0, 8'h3F, 8'h7E, 8'h0F, 64'h1111, 1, "R3");
    step(0, 0, 0, 8'h00, 8'h00, 8'h0F, 64'h0, 0, "R3");

    // R1: clear alone, then async reset mid-run
    step(0, 0, 1, 8'h00, 8'h00, 8'hC3, 64'h0, 0, "R1");
    step(0, 0, 0, 8'h00, 8'h00, 8'hC3, 64'h0, 0, "R1");
    step(0, 0, 0, 8'h00, 8'h00, 8'hC3, 64'h0, 1, "R1");
    step(1, 0, 0, 8'h66, 8'h99, 8'hC3, 64'h7777, 0, "R3");
    step(0, 0, 0, 8'h00, 8'h00, 8'hC3, 64'h0, 0, "R3");
    #1 rst_n = 1'b0;
    model_reset();
    #2 compare("R1");
    @(negedge clk_syn);
    rst_n = 1'b1;
    step(0, 0, 0, 8'h00, 8'h00, 8'h3C, 64'h0, 0, "R1");
    step(0, 0, 0, 8'h00, 8'h00, 8'h3C, 64'h0, 1, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule